// File: doc/BRIEF.md
# Tri-Level Gate Sequencer for a Buck Phase

This block sequences the two switch enables of one synchronous buck phase. A controller sends a command with three levels, which arrives already decoded into high, low and mid. A high command selects the high-side switch and a low command selects the low-side switch. The mid command has two uses. When current is still flowing, the low-side switch conducts only until the inductor current reaches zero, which gives diode emulation. When the phase is shed, nothing conducts.

Two clamp flags from the current sensing path limit conduction within a single switching cycle without raising any fault. A positive clamp ends the present high-side pulse. A negative clamp ends low-side conduction. A supervisor enable forces both switches off.

Every turn-on waits out a programmable number of dead cycles during which both enables are low, so the two enables can never overlap.

Top module: `buck_gate_seq`

## Requirements
- R1: With `drv_en` high, a high command (`pwm_cmd` = 2'b01) turns `hs_gate` on and keeps `ls_gate` off. `hs_gate` turns on once the dead-time rule (R8) allows it.
- R2: With `drv_en` high, a low command (`pwm_cmd` = 2'b00) turns `ls_gate` on and keeps `hs_gate` off, subject to R8 and R6.
- R3: A mid command (`pwm_cmd` = 2'b10 or 2'b11) never turns `hs_gate` on. In mid, `ls_gate` may conduct until `i_zero` is sampled high. `ls_gate` is then low from the next edge, and stays low for as long as the command remains mid.
- R4: A mid command that arrives while `i_zero` is already high keeps both gates off for the whole mid interval (phase shed).
- R5: If `clamp_pos` is sampled high while `hs_gate` is on, `hs_gate` is low from the next edge. It stays low while the command remains high, and only a fresh high command after a non-high one turns it on again.
- R6: If `clamp_neg` is sampled high while `ls_gate` is on, `ls_gate` is low from the next edge. It stays low until a high command has been seen.
- R7: `hs_gate` and `ls_gate` are never high in the same cycle.
- R8: Between any gate turning off and any gate turning on, both gates stay low for exactly max(`dead_cyc`, 1) cycles when the request is waiting.
- R9: When `drv_en` is sampled low, both gates are low from the next edge, whatever the other inputs do.
- R10: During reset both gates are low. The first turn-on after reset needs no dead wait, so a high command held through reset gives `hs_gate` high after the first edge following release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Supervisor enable; low forces both gates off |
| pwm_cmd | input | 2 | Decoded command: 00 low, 01 high, 1x mid |
| i_zero | input | 1 | Inductor current has reached zero |
| clamp_pos | input | 1 | Positive (sourcing) current clamp flag |
| clamp_neg | input | 1 | Negative (sinking) current clamp flag |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |

## Verification
The command is stepped through high, low and mid in several orders. This separates dead-time waits from mode decoding, and it shows whether the mid state is handled as diode emulation (zero flag rising late) or as a shed (zero flag already high). Clamp flags are raised during the conduction they target and then left low. This shows whether the cut is held until the correct release event and not merely for one cycle. The dead time is measured at 0, 1 and 5 cycles to expose off-by-one gaps, and the enable is pulled low while the other inputs churn to confirm that it overrides everything.

// File: rtl/gate_pkg.sv
package gate_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_MID  = 2'b10,
    CMD_MIDX = 2'b11
  } gate_cmd_e;

  localparam int SW_HS = 0;
  localparam int SW_LS = 1;

  // Mid is any code with the upper bit set.
  function automatic logic cmd_is_mid(logic [1:0] c);
    return c[1];
  endfunction

  // A turn-on is allowed once the count of off cycles reaches the dead time.
  function automatic logic gap_met(int unsigned off_cycles, int unsigned dead);
    return off_cycles >= dead;
  endfunction

endpackage

// File: rtl/gate_mode_ctl.sv
module gate_mode_ctl
  import gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_en,
  input  logic [1:0] pwm_cmd,
  input  logic       i_zero,
  input  logic       clamp_pos,
  input  logic       clamp_neg,
  input  logic       hs_on_q,
  input  logic       ls_on_q,
  output logic       hs_req,
  output logic       ls_req,
  output logic       hs_cut_evt,
  output logic       ls_cut_evt,
  output logic       de_stop_evt
);

  logic cmd_high, cmd_low, cmd_mid;
  logic hs_cut_q, ls_cut_q, de_done_q;
  logic ls_block;

  assign cmd_high = (pwm_cmd == CMD_HIGH);
  assign cmd_low  = (pwm_cmd == CMD_LOW);
  assign cmd_mid  = cmd_is_mid(pwm_cmd);

  // Named events for the checks.
  assign hs_cut_evt  = clamp_pos & hs_on_q;
  assign ls_cut_evt  = clamp_neg & ls_on_q;
  assign de_stop_evt = cmd_mid & i_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cut_q  <= 1'b0;
      ls_cut_q  <= 1'b0;
      de_done_q <= 1'b0;
    end else begin
      // The high-side cut is held while the command stays high.
      hs_cut_q  <= cmd_high ? (hs_cut_q | hs_cut_evt) : 1'b0;
      // The low-side cut is released by the next high command.
      ls_cut_q  <= cmd_high ? 1'b0 : (ls_cut_q | ls_cut_evt);
      // The zero-current stop is held for the rest of the mid interval.
      de_done_q <= cmd_mid ? (de_done_q | de_stop_evt) : 1'b0;
    end
  end

  assign ls_block = ls_cut_q | ls_cut_evt;

  always_comb begin
    hs_req = drv_en & cmd_high & ~hs_cut_q & ~hs_cut_evt;
    ls_req = drv_en & ~ls_block &
             (cmd_low | (cmd_mid & ~de_done_q & ~i_zero));
  end

  // R7: the two requests come from disjoint command decodes.
  a_r7_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req));

  // R5: a latched cut keeps the high side unrequested while the command stays high.
  a_r5_cut_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cut_evt && cmd_high) |=> (!hs_req || !cmd_high ||
                                  $past(pwm_cmd) != pwm_cmd));

endmodule

// File: rtl/gate_interlock.sv
module gate_interlock
  import gate_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_req,
  input  logic            ls_req,
  input  logic [DT_W-1:0] dead_cyc,
  output logic            hs_on,
  output logic            ls_on,
  output logic [1:0]      turn_on_evt
);

  localparam logic [DT_W-1:0] CNT_MAX = '1;
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  logic [1:0]      req;
  logic [1:0]      on_q;
  logic [1:0]      on_d;
  logic [DT_W-1:0] off_cnt;
  logic            any_on;
  logic            gap_ok;

  assign req[SW_HS] = hs_req;
  assign req[SW_LS] = ls_req;
  assign any_on     = |on_q;
  assign gap_ok     = gap_met(32'(off_cnt), 32'(dead_cyc));

  // Counts the cycles with both gates off; it saturates and is seeded full at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              off_cnt <= CNT_MAX;
    else if (any_on)         off_cnt <= CNT_ONE;
    else if (off_cnt != CNT_MAX) off_cnt <= off_cnt + CNT_ONE;
  end

  for (genvar i = 0; i < 2; i++) begin : g_sw
    // Break before make: the opposite gate must already be low.
    assign on_d[i]        = req[i] & ~on_q[1-i] & (on_q[i] | gap_ok);
    assign turn_on_evt[i] = on_d[i] & ~on_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) on_q[i] <= 1'b0;
      else        on_q[i] <= on_d[i];
    end

    // R8: every rising gate had its partner low in the cycle before.
    a_r8_break_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_q[i]) |-> $past(!on_q[1-i]));

    // R8: a gate rises only when it was requested at that edge.
    a_r8_rise_requested: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_q[i]) |-> $past(req[i]));
  end

  assign hs_on = on_q[SW_HS];
  assign ls_on = on_q[SW_LS];

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import gate_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_en,
  input  logic [1:0]      pwm_cmd,
  input  logic            i_zero,
  input  logic            clamp_pos,
  input  logic            clamp_neg,
  input  logic [DT_W-1:0] dead_cyc,
  output logic            hs_gate,
  output logic            ls_gate
);

  logic       hs_req, ls_req;
  logic       hs_cut_evt, ls_cut_evt, de_stop_evt;
  logic [1:0] turn_on_evt;

  gate_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_en      (drv_en),
    .pwm_cmd     (pwm_cmd),
    .i_zero      (i_zero),
    .clamp_pos   (clamp_pos),
    .clamp_neg   (clamp_neg),
    .hs_on_q     (hs_gate),
    .ls_on_q     (ls_gate),
    .hs_req      (hs_req),
    .ls_req      (ls_req),
    .hs_cut_evt  (hs_cut_evt),
    .ls_cut_evt  (ls_cut_evt),
    .de_stop_evt (de_stop_evt)
  );

  gate_interlock #(.DT_W(DT_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_req      (hs_req),
    .ls_req      (ls_req),
    .dead_cyc    (dead_cyc),
    .hs_on       (hs_gate),
    .ls_on       (ls_gate),
    .turn_on_evt (turn_on_evt)
  );

  // R7: the gates never overlap.
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R9: the enable overrides every other input.
  a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> (!hs_gate && !ls_gate));

  // R5: the positive clamp ends the high-side pulse.
  a_r5_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    hs_cut_evt |=> !hs_gate);

  // R6: the negative clamp ends low-side conduction.
  a_r6_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ls_cut_evt |=> !ls_gate);

  // R3: the zero-current flag in mid ends low-side conduction.
  a_r3_zero_stop: assert property (@(posedge clk) disable iff (!rst_n)
    de_stop_evt |=> !ls_gate);

  // R1/R3: the high side conducts only after a high command.
  a_r1_hs_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> ($past(pwm_cmd) == CMD_HIGH));

  // R2: the low side never conducts after a high command.
  a_r2_ls_not_high: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate |-> ($past(pwm_cmd) != CMD_HIGH));

  // R8: the interlock reports at most one turn-on per edge.
  a_r8_single_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(turn_on_evt));

  // R10: both gates are low while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_off: assert (!hs_gate && !ls_gate);
    end
  end

endmodule

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DT_W       = 4;
  localparam int NV         = 31;

  // Layout: cmd[11:10] en[9] zero[8] pclamp[7] nclamp[6] exp_hs[5] exp_ls[4] req[3:0]
  localparam logic [11:0] TBL [NV] = '{
    12'b01_1_0_0_0_1_0_0001, // v0  R1 high, hs on at once (R10 no wait)
    12'b01_1_0_0_0_1_0_0001, // v1  R1
    12'b00_1_0_0_0_0_0_1000, // v2  R8 hs off
    12'b00_1_0_0_0_0_0_1000, // v3  R8 dead cycle 2
    12'b00_1_0_0_0_0_1_0010, // v4  R2 ls on
    12'b00_1_0_0_0_0_1_0010, // v5  R2
    12'b10_1_0_0_0_0_1_0011, // v6  R3 mid keeps ls
    12'b10_1_1_0_0_0_0_0011, // v7  R3 zero ends ls
    12'b10_1_0_0_0_0_0_0011, // v8  R3 stop latched
    12'b01_1_0_0_0_1_0_0001, // v9  R1
    12'b01_1_0_1_0_0_0_0101, // v10 R5 clamp cut
    12'b01_1_0_0_0_0_0_0101, // v11 R5 held
    12'b01_1_0_0_0_0_0_0101, // v12 R5 held
    12'b00_1_0_0_0_0_1_0010, // v13 R2
    12'b00_1_0_0_1_0_0_0110, // v14 R6 neg clamp
    12'b00_1_0_0_0_0_0_0110, // v15 R6 held
    12'b10_1_0_0_0_0_0_0110, // v16 R6 held into mid
    12'b01_1_0_0_0_1_0_0001, // v17 R1
    12'b01_0_0_0_0_0_0_1001, // v18 R9
    12'b00_0_0_0_0_0_0_1001, // v19 R9
    12'b00_1_0_0_0_0_1_0010, // v20 R2
    12'b10_1_1_0_0_0_0_0100, // v21 R4
    12'b00_1_0_0_0_0_0_1000, // v22 R8
    12'b00_1_0_0_0_0_1_1000, // v23 R8
    12'b10_1_1_0_0_0_0_0100, // v24 R4
    12'b10_1_1_0_0_0_0_0100, // v25 R4 shed
    12'b11_1_0_0_0_0_0_0011, // v26 R3 code 11 is mid
    12'b01_1_0_0_0_1_0_0001, // v27 R1
    12'b10_1_0_0_0_0_0_0011, // v28 R3 hs off
    12'b10_1_0_0_0_0_0_0011, // v29 R3 dead wait
    12'b10_1_0_0_0_0_1_0011  // v30 R3 ls on in mid
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            drv_en = 1'b0;
  logic [1:0]      pwm_cmd = 2'b10;
  logic            i_zero = 1'b0;
  logic            clamp_pos = 1'b0;
  logic            clamp_neg = 1'b0;
  logic [DT_W-1:0] dead_cyc = 4'd2;
  logic            hs_gate, ls_gate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_gate_seq #(.DT_W(DT_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_en    (drv_en),
    .pwm_cmd   (pwm_cmd),
    .i_zero    (i_zero),
    .clamp_pos (clamp_pos),
    .clamp_neg (clamp_neg),
    .dead_cyc  (dead_cyc),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
  );

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input int rq,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: hs/ls=%b expected %b", rq, what, act, exp);
    end
  endtask

  // R7: overlap check on every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (hs_gate && ls_gate) begin
        n_fail++;
        $display("FAIL R7 overlap: hs/ls=11 expected not 11");
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Dead-time measurement from high to low (R8).
  task automatic gap_run(input logic [DT_W-1:0] d);
    int gap;
    int expv;
    dead_cyc = d;
    pwm_cmd  = 2'b01;
    for (int k = 0; k < 40 && !hs_gate; k++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    pwm_cmd = 2'b00;
    gap = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ls_gate) break;
      if (!hs_gate) gap++;
    end
    expv = (d == 0) ? 1 : int'(d);
    chk(2'(gap), 2'(expv), 8, $sformatf("R8 gap dead=%0d got %0d want %0d", d, gap, expv));
    n_chk++;
    if (gap != expv) begin
      n_fail++;
      $display("FAIL R8 gap length: %0d expected %0d", gap, expv);
    end
  endtask

  initial begin
    // R10: reset state with a high command waiting.
    pwm_cmd = 2'b01;
    drv_en  = 1'b1;
    repeat (3) @(negedge clk);
    chk({hs_gate, ls_gate}, 2'b00, 10, "R10 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({hs_gate, ls_gate}, 2'b10, 10, "R10 first turn-on");
    // Park in shed, then restart from reset for the table.
    rst_n   = 1'b0;
    pwm_cmd = 2'b10;
    i_zero  = 1'b1;
    @(negedge clk);
    rst_n  = 1'b1;
    @(negedge clk);
    chk({hs_gate, ls_gate}, 2'b00, 4, "R4 shed after reset");

    dead_cyc = 4'd2;
    for (int i = 0; i < NV; i++) begin
      pwm_cmd   = TBL[i][11:10];
      drv_en    = TBL[i][9];
      i_zero    = TBL[i][8];
      clamp_pos = TBL[i][7];
      clamp_neg = TBL[i][6];
      @(negedge clk);
      chk({hs_gate, ls_gate}, TBL[i][5:4], int'(TBL[i][3:0]),
          $sformatf("vector %0d", i));
    end

    // R8: dead times 0, 1 and 5.
    i_zero = 1'b0;
    clamp_pos = 1'b0;
    clamp_neg = 1'b0;
    drv_en = 1'b1;
    gap_run(4'd0);
    gap_run(4'd1);
    gap_run(4'd5);

    // R9: enable low while every other input churns.
    drv_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      pwm_cmd   = 2'(k);
      clamp_pos = k[0];
      clamp_neg = k[1];
      i_zero    = k[2];
      @(negedge clk);
      chk({hs_gate, ls_gate}, 2'b00, 9, "R9 disabled");
    end

    // R5: pulse resumes only after a fresh high command.
    drv_en = 1'b1; dead_cyc = 4'd1; i_zero = 1'b0; clamp_neg = 1'b0; clamp_pos = 1'b0;
    pwm_cmd = 2'b01;
    repeat (3) @(negedge clk);
    chk({hs_gate, ls_gate}, 2'b10, 1, "R1 high after disable");
    clamp_pos = 1'b1;
    @(negedge clk);
    clamp_pos = 1'b0;
    chk({hs_gate, ls_gate}, 2'b00, 5, "R5 cut");
    repeat (3) @(negedge clk);
    chk({hs_gate, ls_gate}, 2'b00, 5, "R5 still cut");
    pwm_cmd = 2'b10; i_zero = 1'b1;
    @(negedge clk);
    pwm_cmd = 2'b01; i_zero = 1'b0;
    @(negedge clk);
    chk({hs_gate, ls_gate}, 2'b10, 5, "R5 fresh high");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

endmodule